// File: doc/BRIEF.md
# LIN Bus Remote Wake Detector with Stuck-Dominant Lockout

This block sits beside a LIN receiver and watches the bus level while the node rests in a low-power state. A remote wake-up is accepted only once the bus has been dominant without interruption for a filter time measured in 1 µs ticks. If the bus is already dominant when the node goes to sleep, the bus is treated as stuck. Wake detection is then blocked until the bus has been recessive without a break for a clear time. This keeps a shorted or stuck bus from waking the node again and again.

An accepted wake produces a single-cycle request strobe and sets a sticky flag, which stays set until a clear strobe arrives. It is also shown on the receive-data output. In pulse mode the output goes low for a fixed number of ticks. In level mode it is held low until sleep is left. While the node is awake, the receive-data output follows the synchronised bus level. While it is asleep and no wake has been seen, the output rests high.

Top module: `lin_wake_detect`

## Requirements
- R1: The bus input passes through a two-flop synchroniser. While `sleep_i` is low, `rxd_o` equals the bus level and follows a change of `bus_i` after the second rising clock edge.
- R2: The bus level is 1 for recessive and 0 for dominant. In sleep with detection armed, `wake_req_o` rises after the clock edge that takes the WAKE_US-th consecutive dominant sample on a tick. WAKE_US-1 dominant samples followed by a recessive one produce no wake.
- R3: A recessive sample taken on a tick before the wake threshold is reached restarts the dominant count from zero.
- R4: The counters advance only on clock edges where `tick_i` is high. A dominant bus with no ticks never produces a wake.
- R5: If the synchronised bus is dominant at the clock edge where sleep is entered, detection is locked out. A dominant bus of any length then produces no wake.
- R6: The lockout clears after CLEAR_US consecutive recessive samples taken on ticks. CLEAR_US-1 recessive samples followed by a dominant one leave it locked.
- R7: `wake_req_o` is high for exactly one clock cycle per wake and is never raised while `sleep_i` is low.
- R8: `wake_flag_o` is set in the same cycle as `wake_req_o` and stays set, even after sleep is left, until `flag_clr_i` is high at a clock edge.
- R9: During sleep, `rxd_o` is 1 until a wake is detected, whatever the bus level.
- R10: With `pulse_mode_i` = 1 at the wake, `rxd_o` is 0 for exactly PULSE_US ticks starting at the wake edge, and 1 afterwards.
- R11: With `pulse_mode_i` = 0 at the wake, `rxd_o` stays 0 until sleep is left, even when the bus returns to recessive. After that it follows the bus again.
- R12: At most one wake is reported per sleep period. After a wake, further dominant time gives no new request until sleep is left and entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle enable every 1 µs |
| sleep_i | input | 1 | High while the node is in a low-power state |
| bus_i | input | 1 | Raw receiver level, 1 recessive, 0 dominant |
| pulse_mode_i | input | 1 | 1 selects pulse reporting on rxd_o, 0 selects held-low reporting |
| flag_clr_i | input | 1 | Clears the sticky wake flag |
| wake_req_o | output | 1 | Single-cycle wake request |
| wake_flag_o | output | 1 | Sticky wake flag |
| rxd_o | output | 1 | Receive-data pin level |

## Verification
With a tick on every clock, a level driven on `bus_i` at a falling edge is first counted at the third rising edge, so a wake is due at rising edge WAKE_US+2 after dominant is driven. The bench counts rising edges after each stimulus and samples shortly after each edge, so it records the exact edge of the first request and the number of low receive-data samples. It compares these against values derived from the requirements, and it compares lockout runs with hold times of exactly CLEAR_US and CLEAR_US-1 recessive samples. On a tick the counted sample is the bus level held for a given number of cycles, because the synchroniser delays both edges of that level equally.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_LOCKED = 2'd1,
    WK_ARMED  = 2'd2,
    WK_WOKEN  = 2'd3
  } wk_state_e;
endpackage

// File: rtl/lin_wake_sync.sv
module lin_wake_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // Chain of flops, stage 0 takes the raw input
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= RST_VAL;
        else         sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[s] <= RST_VAL;
        else         sr_q[s] <= sr_q[s-1];
      end
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lin_wake_fsm.sv
module lin_wake_fsm
  import lin_wake_pkg::*;
#(
  parameter int WAKE_US  = 100,
  parameter int CLEAR_US = 30
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      sleep_i,
  input  logic      bus_dom_i,
  output wk_state_e state_o,
  output logic      wake_hit_o
);
  localparam int CNT_MAX = (WAKE_US > CLEAR_US) ? WAKE_US : CLEAR_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_US - 1);
  localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(CLEAR_US - 1);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  wk_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wake_hit_o = 1'b0;
    if (!sleep_i) begin
      state_d = WK_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          // bus already dominant at sleep entry counts as stuck
          state_d = bus_dom_i ? WK_LOCKED : WK_ARMED;
          cnt_d   = '0;
        end
        WK_LOCKED: begin
          if (tick_i) begin
            if (bus_dom_i) begin
              cnt_d = '0;
            end else if (cnt_q == CLEAR_LAST) begin
              state_d = WK_ARMED;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        WK_ARMED: begin
          if (tick_i) begin
            if (!bus_dom_i) begin
              cnt_d = '0;
            end else if (cnt_q == WAKE_LAST) begin
              state_d    = WK_WOKEN;
              cnt_d      = '0;
              wake_hit_o = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        default: begin
          state_d = WK_WOKEN;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  assert_lock_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WK_LOCKED) |-> (cnt_q < CNT_W'(CLEAR_US)));
  assert_arm_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WK_ARMED) |-> (cnt_q < CNT_W'(WAKE_US)));
  assert_one_per_sleep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WK_WOKEN && sleep_i) |-> !wake_hit_o);
endmodule

// File: rtl/lin_wake_rxd.sv
module lin_wake_rxd #(
  parameter int PULSE_US = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sleep_i,
  input  logic asleep_i,
  input  logic wake_hit_i,
  input  logic pulse_mode_i,
  input  logic bus_s_i,
  output logic rxd_o
);
  localparam int PW = $clog2(PULSE_US + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_US);
  localparam logic [PW-1:0] ONE        = PW'(1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          hold_q, hold_d;

  always_comb begin
    pcnt_d = pcnt_q;
    hold_d = hold_q;
    if (!sleep_i) begin
      pcnt_d = '0;
      hold_d = 1'b0;
    end else if (wake_hit_i) begin
      if (pulse_mode_i) pcnt_d = PULSE_LOAD;
      else              hold_d = 1'b1;
    end else if (tick_i && pcnt_q != '0) begin
      pcnt_d = pcnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      hold_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      hold_q <= hold_d;
    end
  end

  // awake: mirror the bus; asleep: high unless a wake is being shown
  assign rxd_o = asleep_i ? !(hold_q || (pcnt_q != '0)) : bus_s_i;

  assert_pulse_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= PULSE_LOAD);
  assert_modes_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_q && (pcnt_q != '0)));
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect
  import lin_wake_pkg::*;
#(
  parameter int WAKE_US  = 100,
  parameter int CLEAR_US = 30,
  parameter int PULSE_US = 10,
  parameter int SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sleep_i,
  input  logic bus_i,
  input  logic pulse_mode_i,
  input  logic flag_clr_i,
  output logic wake_req_o,
  output logic wake_flag_o,
  output logic rxd_o
);
  logic      rst_n_s;
  logic      bus_s;
  logic      bus_dom;
  logic      wake_hit;
  wk_state_e state;
  logic      req_q, flag_q, flag_d;

  lin_wake_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n_s)
  );

  lin_wake_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   (bus_i),
    .q_o   (bus_s)
  );

  assign bus_dom = !bus_s;

  lin_wake_fsm #(.WAKE_US(WAKE_US), .CLEAR_US(CLEAR_US)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .tick_i    (tick_i),
    .sleep_i   (sleep_i),
    .bus_dom_i (bus_dom),
    .state_o   (state),
    .wake_hit_o(wake_hit)
  );

  lin_wake_rxd #(.PULSE_US(PULSE_US)) u_rxd (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .tick_i      (tick_i),
    .sleep_i     (sleep_i),
    .asleep_i    (state != WK_IDLE),
    .wake_hit_i  (wake_hit),
    .pulse_mode_i(pulse_mode_i),
    .bus_s_i     (bus_s),
    .rxd_o       (rxd_o)
  );

  always_comb begin
    flag_d = flag_q;
    if (wake_hit)        flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= wake_hit;
      flag_q <= flag_d;
    end
  end

  assign wake_req_o  = req_q;
  assign wake_flag_o = flag_q;

  assert_req_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wake_req_o |=> !wake_req_o);
  assert_none_awake_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !sleep_i |=> !wake_req_o);
  assert_wake_after_dom_R2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wake_req_o |-> $past(bus_dom));
  assert_flag_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    wake_req_o |-> wake_flag_o);
  assert_flag_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(wake_flag_o) |-> $past(flag_clr_i));
endmodule

// File: tb/lin_wake_detect_tb.sv
module lin_wake_detect_tb;
  localparam int WAKE  = 100;
  localparam int CLEAR = 30;
  localparam int PULSE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic sleep = 1'b0;
  logic bus = 1'b1;
  logic pmode = 1'b1;
  logic fclr = 1'b0;
  logic wreq, wflag, rxd;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lin_wake_detect #(.WAKE_US(WAKE), .CLEAR_US(CLEAR), .PULSE_US(PULSE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep), .bus_i(bus),
    .pulse_mode_i(pmode), .flag_clr_i(fclr),
    .wake_req_o(wreq), .wake_flag_o(wflag), .rxd_o(rxd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #2;
  endtask

  // counts edges; reports first request edge, request count, low rxd samples
  task automatic watch(input int n, output int first, output int reqs, output int lows);
    first = 0; reqs = 0; lows = 0;
    for (int i = 1; i <= n; i++) begin
      edge_s();
      if (wreq) begin reqs++; if (first == 0) first = i; end
      if (!rxd) lows++;
    end
  endtask

  task automatic drv_bus(input logic v);
    @(negedge clk); bus = v;
  endtask

  task automatic drv_sleep(input logic v);
    @(negedge clk); sleep = v;
  endtask

  task automatic t_reset();
    check("R7 reset wake_req", int'(wreq), 0);
    check("R8 reset wake_flag", int'(wflag), 0);
    check("R1 reset rxd", int'(rxd), 1);
  endtask

  task automatic t_awake();
    int f, r, l;
    drv_bus(1'b0);
    edge_s();
    check("R1 rxd after one edge", int'(rxd), 1);
    edge_s();
    check("R1 rxd after two edges", int'(rxd), 0);
    watch(300, f, r, l);
    check("R7 no wake while awake", r, 0);
    drv_bus(1'b1);
    watch(3, f, r, l);
    check("R1 rxd back high", int'(rxd), 1);
  endtask

  task automatic t_pulse_wake();
    int f, r, l;
    pmode = 1'b1;
    drv_sleep(1'b1);
    watch(3, f, r, l);
    drv_bus(1'b0);
    watch(WAKE + 2 + 60, f, r, l);
    check("R2 wake edge", f, WAKE + 2);
    check("R12 one request per sleep", r, 1);
    check("R10 pulse low samples", l, PULSE);
    check("R10 rxd high after pulse", int'(rxd), 1);
    check("R8 flag set", int'(wflag), 1);
    drv_bus(1'b1);
    drv_sleep(1'b0);
    watch(3, f, r, l);
    check("R8 flag kept after sleep left", int'(wflag), 1);
    @(negedge clk); fclr = 1'b1;
    @(negedge clk); fclr = 1'b0;
    check("R8 flag cleared", int'(wflag), 0);
  endtask

  task automatic t_restart_level();
    int f, r, l, r2, l2;
    pmode = 1'b0;
    drv_sleep(1'b1);
    watch(3, f, r, l);
    drv_bus(1'b0);
    watch(WAKE - 1, f, r, l);
    drv_bus(1'b1);
    watch(4, f, r2, l2);
    check("R2 threshold minus one no wake", r + r2, 0);
    check("R9 rxd high before wake", l + l2, 0);
    drv_bus(1'b0);
    watch(WAKE + 5, f, r, l);
    check("R3 restart then wake edge", f, WAKE + 2);
    check("R11 held low samples", l, 4);
    drv_bus(1'b1);
    watch(5, f, r, l);
    check("R11 held low despite recessive bus", l, 5);
    drv_sleep(1'b0);
    edge_s();
    check("R11 rxd follows bus after sleep left", int'(rxd), 1);
    watch(3, f, r, l);
  endtask

  task automatic t_tick_gate();
    int f, r, l;
    pmode = 1'b1;
    tick = 1'b0;
    drv_sleep(1'b1);
    watch(3, f, r, l);
    drv_bus(1'b0);
    watch(400, f, r, l);
    check("R4 no wake without ticks", r, 0);
    @(negedge clk); tick = 1'b1;
    watch(WAKE + 3, f, r, l);
    check("R4 wake after ticks resume", f, WAKE);
    drv_bus(1'b1);
    drv_sleep(1'b0);
    watch(3, f, r, l);
  endtask

  task automatic t_lockout();
    int f, r, l;
    pmode = 1'b1;
    drv_bus(1'b0);
    watch(3, f, r, l);
    drv_sleep(1'b1);
    watch(300, f, r, l);
    check("R5 locked, no wake", r, 0);
    check("R9 rxd high while locked", l, 0);
    drv_bus(1'b1);
    watch(CLEAR - 1, f, r, l);
    drv_bus(1'b0);
    watch(300, f, r, l);
    check("R6 short recessive keeps lock", r, 0);
    drv_bus(1'b1);
    watch(CLEAR, f, r, l);
    drv_bus(1'b0);
    watch(WAKE + 5, f, r, l);
    check("R6 lock cleared, wake edge", f, WAKE + 2);
    drv_bus(1'b1);
    drv_sleep(1'b0);
    watch(3, f, r, l);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    t_reset();
    t_awake();
    t_pulse_wake();
    t_restart_level();
    t_tick_gate();
    t_lockout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule